// File: doc/BRIEF.md
# USB2 Root Hub Port Status and Control Registers

This block holds the 32-bit status and control word of each USB2 root hub port and exposes all of them on a simple register bus. Each port's word sits at its own address. Port 1 is at 480h, and each further port follows 10h above the one before it. A read returns the addressed word combinationally. A write updates it at the next clock edge. Addresses that match no port read as zero, and writes to them are dropped.

Software uses the word to request a bus reset or a warm reset, to switch port power, to select indicator and wake behaviour, and to write the link state. A link-state write only takes effect when the strobe bit is set in the same write. Change flags are cleared by writing 1 to them.

A port state machine outside this block drives per-port status levels: connect, cold attach, over-current and speed. It also drives single-cycle events: enable, fault-disable, reset done, warm reset done, link state update and configuration error. These events set the matching flags and bits. The block brings out each port's pending reset requests, its power bit and its link state.

Top module: `usb2p_hub_regs`

## Requirements
- R1: After reset every port word reads 0000_02A0h: power (bit 9) is 1, link state (bits 8:5) is 5h, and every other field is 0.
- R2: Port k (1..N) is at 480h + 10h*(k-1). Any other address reads 0, and a write to it changes no port.
- R3: Flags in bits 23..17 clear when 1 is written to them. Writing 0 to them leaves them unchanged.
- R4: When a hardware set event and a write-1-to-clear hit the same flag in one cycle, the flag ends up set.
- R5: Bit 0 follows the connect input and bit 24 follows the cold attach input. The connect change flag (bit 17) is set whenever either of them changes.
- R6: Port enabled (bit 1) becomes 1 only on the enable event. Writing 1 to it clears it. Writing 1 while it is 0 does not set it.
- R7: The enable change flag (bit 18) is set when a fault event clears an enabled port. It is not set when software clears the port.
- R8: The link state field (bits 8:5) takes write data only when bit 16 is 1 in the same write. Bit 16 always reads 0.
- R9: Writing 1 to bit 4 sets the bus reset request. The request stays set until the reset-done event and reads 0 in the cycle after it. At that point the reset change flag (bit 21) is set.
- R10: Writing 1 to bit 31 sets the warm reset request. The request clears after the warm-done event, and the warm reset change flag (bit 19) is then set.
- R11: Power (bit 9), indicator (bits 15:14), wake enables (bits 27:25) and removable (bit 30) read back as written. Reserved bits 29:28 and bit 2 read 0. Speed (bits 13:10) shows the speed input.
- R12: Bit 3 follows the over-current input, and the over-current change flag (bit 20) is set whenever that input changes.
- R13: A link update event loads the link state from the event value, overriding any software write in the same cycle, and sets the link change flag (bit 22). A configuration error event sets bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed port, 0 if no match |
| ccs_in | input | N_PORTS | Connect level per port |
| cas_in | input | N_PORTS | Cold attach level per port |
| oc_in | input | N_PORTS | Over-current level per port |
| speed_in | input | 4*N_PORTS | Speed code per port |
| en_set | input | N_PORTS | Enable event pulse |
| fault_dis | input | N_PORTS | Fault-disable event pulse |
| reset_done | input | N_PORTS | Bus reset done pulse |
| warm_done | input | N_PORTS | Warm reset done pulse |
| link_we | input | N_PORTS | Link state update pulse |
| link_val | input | 4*N_PORTS | Link state value for the update |
| cfg_err | input | N_PORTS | Configuration error pulse |
| pr_req | output | N_PORTS | Pending bus reset request |
| wpr_req | output | N_PORTS | Pending warm reset request |
| pp_out | output | N_PORTS | Port power bit |
| pls_out | output | 4*N_PORTS | Current link state per port |

## Verification
The assertions assume that every event input is a single-cycle pulse. They also assume that the enable and fault events of one port never arrive in the same cycle, since only then does a rise of the enabled bit always trace back to an enable pulse. The directed stimulus raises each event for exactly one clock, drives it at the falling edge, and keeps enable and fault pulses apart. It issues reset-done and warm-done only while the matching request is pending, which matches how the port state machine finishes a reset sequence.

// File: rtl/usb2p_pkg.sv
package usb2p_pkg;
  localparam int WORD_W  = 32;
  localparam int SPEED_W = 4;
  localparam int PLS_W   = 4;
  localparam logic [PLS_W-1:0] PLS_RST = 4'h5;

  // bit positions decoded by software
  localparam int B_CCS  = 0;
  localparam int B_PED  = 1;
  localparam int B_OCA  = 3;
  localparam int B_PR   = 4;
  localparam int B_PLS  = 5;
  localparam int B_PP   = 9;
  localparam int B_SPD  = 10;
  localparam int B_PIC  = 14;
  localparam int B_LWS  = 16;
  localparam int B_CSC  = 17;
  localparam int B_PEC  = 18;
  localparam int B_WRC  = 19;
  localparam int B_OCC  = 20;
  localparam int B_PRC  = 21;
  localparam int B_PLC  = 22;
  localparam int B_CEC  = 23;
  localparam int B_CAS  = 24;
  localparam int B_WAKE = 25;
  localparam int B_DR   = 30;
  localparam int B_WPR  = 31;

  // a hardware set always beats a software clear
  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic [31:0] port_addr(input logic [31:0] base,
                                            input logic [31:0] stride,
                                            input int idx);
    return base + stride * idx;
  endfunction
endpackage

// File: rtl/usb2p_addr_dec.sv
module usb2p_addr_dec
  import usb2p_pkg::*;
#(
  parameter int N_PORTS = 10,
  parameter int ADDR_W  = 12,
  parameter logic [31:0] BASE   = 32'h480,
  parameter logic [31:0] STRIDE = 32'h10
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [N_PORTS-1:0] sel
);
  for (genvar i = 0; i < N_PORTS; i++) begin : g_sel
    localparam logic [31:0] ADDR_I = port_addr(BASE, STRIDE, i);
    assign sel[i] = (addr == ADDR_I[ADDR_W-1:0]);
  end
endmodule

// File: rtl/usb2p_port_reg.sv
module usb2p_port_reg
  import usb2p_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ccs_in,
  input  logic              cas_in,
  input  logic              oc_in,
  input  logic [SPEED_W-1:0] speed_in,
  input  logic              en_set,
  input  logic              fault_dis,
  input  logic              reset_done,
  input  logic              warm_done,
  input  logic              link_we,
  input  logic [PLS_W-1:0]  link_val,
  input  logic              cfg_err,
  output logic [WORD_W-1:0] word,
  output logic              pr_q,
  output logic              wpr_q,
  output logic              pp_q,
  output logic [PLS_W-1:0]  pls_q
);
  logic ccs_q, cas_q, oca_q, ped_q, dr_q;
  logic [1:0] pic_q;
  logic [2:0] wake_q;
  logic csc_q, pec_q, wrc_q, occ_q, prc_q, plc_q, cec_q;

  // named internal events
  logic [WORD_W-1:0] w1;
  logic csc_set, pec_set, wrc_set, occ_set, prc_set, plc_set, cec_set;
  logic ped_clr, sw_lws;

  assign w1      = wr ? wdata : '0;
  assign csc_set = (ccs_in ^ ccs_q) | (cas_in ^ cas_q);
  assign occ_set = oc_in ^ oca_q;
  assign pec_set = fault_dis & ped_q;
  assign prc_set = pr_q & reset_done;
  assign wrc_set = wpr_q & warm_done;
  assign plc_set = link_we;
  assign cec_set = cfg_err;
  assign ped_clr = w1[B_PED] | fault_dis;
  assign sw_lws  = w1[B_LWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccs_q <= 1'b0; cas_q <= 1'b0; oca_q <= 1'b0; ped_q <= 1'b0;
      pr_q <= 1'b0; wpr_q <= 1'b0; pp_q <= 1'b1; pls_q <= PLS_RST;
      dr_q <= 1'b0; pic_q <= '0; wake_q <= '0;
      csc_q <= 1'b0; pec_q <= 1'b0; wrc_q <= 1'b0; occ_q <= 1'b0;
      prc_q <= 1'b0; plc_q <= 1'b0; cec_q <= 1'b0;
    end else begin
      ccs_q <= ccs_in;
      cas_q <= cas_in;
      oca_q <= oc_in;
      if (ped_clr)     ped_q <= 1'b0;
      else if (en_set) ped_q <= 1'b1;
      if (prc_set)       pr_q <= 1'b0;
      else if (w1[B_PR]) pr_q <= 1'b1;
      if (wrc_set)        wpr_q <= 1'b0;
      else if (w1[B_WPR]) wpr_q <= 1'b1;
      if (link_we)     pls_q <= link_val;
      else if (sw_lws) pls_q <= wdata[B_PLS +: PLS_W];
      if (wr) begin
        pp_q   <= wdata[B_PP];
        pic_q  <= wdata[B_PIC +: 2];
        wake_q <= wdata[B_WAKE +: 3];
        dr_q   <= wdata[B_DR];
      end
      csc_q <= flag_next(csc_q, csc_set, w1[B_CSC]);
      pec_q <= flag_next(pec_q, pec_set, w1[B_PEC]);
      wrc_q <= flag_next(wrc_q, wrc_set, w1[B_WRC]);
      occ_q <= flag_next(occ_q, occ_set, w1[B_OCC]);
      prc_q <= flag_next(prc_q, prc_set, w1[B_PRC]);
      plc_q <= flag_next(plc_q, plc_set, w1[B_PLC]);
      cec_q <= flag_next(cec_q, cec_set, w1[B_CEC]);
    end
  end

  always_comb begin
    word = '0;
    word[B_CCS]          = ccs_q;
    word[B_PED]          = ped_q;
    word[B_OCA]          = oca_q;
    word[B_PR]           = pr_q;
    word[B_PLS +: PLS_W] = pls_q;
    word[B_PP]           = pp_q;
    word[B_SPD +: SPEED_W] = speed_in;
    word[B_PIC +: 2]     = pic_q;
    word[B_CSC]          = csc_q;
    word[B_PEC]          = pec_q;
    word[B_WRC]          = wrc_q;
    word[B_OCC]          = occ_q;
    word[B_PRC]          = prc_q;
    word[B_PLC]          = plc_q;
    word[B_CEC]          = cec_q;
    word[B_CAS]          = cas_q;
    word[B_WAKE +: 3]    = wake_q;
    word[B_DR]           = dr_q;
    word[B_WPR]          = wpr_q;
  end
endmodule

// File: rtl/usb2p_hub_regs.sv
module usb2p_hub_regs
  import usb2p_pkg::*;
#(
  parameter int N_PORTS = 10,
  parameter int ADDR_W  = 12,
  parameter logic [31:0] BASE   = 32'h480,
  parameter logic [31:0] STRIDE = 32'h10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [N_PORTS-1:0]         ccs_in,
  input  logic [N_PORTS-1:0]         cas_in,
  input  logic [N_PORTS-1:0]         oc_in,
  input  logic [4*N_PORTS-1:0]       speed_in,
  input  logic [N_PORTS-1:0]         en_set,
  input  logic [N_PORTS-1:0]         fault_dis,
  input  logic [N_PORTS-1:0]         reset_done,
  input  logic [N_PORTS-1:0]         warm_done,
  input  logic [N_PORTS-1:0]         link_we,
  input  logic [4*N_PORTS-1:0]       link_val,
  input  logic [N_PORTS-1:0]         cfg_err,
  output logic [N_PORTS-1:0]         pr_req,
  output logic [N_PORTS-1:0]         wpr_req,
  output logic [N_PORTS-1:0]         pp_out,
  output logic [4*N_PORTS-1:0]       pls_out
);
  logic [N_PORTS-1:0]             sel;
  logic [N_PORTS-1:0][WORD_W-1:0] port_word;

  usb2p_addr_dec #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
  ) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    usb2p_port_reg u_port (
      .clk(clk), .rst_n(rst_n),
      .wr(bus_wr & sel[i]), .wdata(bus_wdata),
      .ccs_in(ccs_in[i]), .cas_in(cas_in[i]), .oc_in(oc_in[i]),
      .speed_in(speed_in[i*SPEED_W +: SPEED_W]),
      .en_set(en_set[i]), .fault_dis(fault_dis[i]),
      .reset_done(reset_done[i]), .warm_done(warm_done[i]),
      .link_we(link_we[i]), .link_val(link_val[i*PLS_W +: PLS_W]),
      .cfg_err(cfg_err[i]),
      .word(port_word[i]),
      .pr_q(pr_req[i]), .wpr_q(wpr_req[i]), .pp_q(pp_out[i]),
      .pls_q(pls_out[i*PLS_W +: PLS_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_PORTS; i++)
      if (sel[i]) bus_rdata = port_word[i];
  end
endmodule

// File: rtl/usb2p_hub_regs_chk.sv
module usb2p_hub_regs_chk #(
  parameter int N_PORTS = 10
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_PORTS-1:0]          en_set,
  input logic [N_PORTS-1:0]          fault_dis,
  input logic [N_PORTS-1:0]          reset_done,
  input logic [N_PORTS-1:0]          warm_done,
  input logic [N_PORTS-1:0]          cfg_err,
  input logic [N_PORTS-1:0]          pr_req,
  input logic [N_PORTS-1:0]          wpr_req,
  input logic [N_PORTS-1:0][31:0]    port_word
);
  for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
    a_r4_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err[i] |=> port_word[i][23]);
    a_r6_ped_rise_from_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_word[i][1]) |-> $past(en_set[i]));
    a_r7_pec_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_dis[i] && port_word[i][1]) |=> port_word[i][18]);
    a_r9_pr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_req[i] && !reset_done[i]) |=> pr_req[i]);
    a_r9_prc_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_req[i] && reset_done[i]) |=> (!pr_req[i] && port_word[i][21]));
    a_r10_wrc_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      (wpr_req[i] && warm_done[i]) |=> (!wpr_req[i] && port_word[i][19]));
  end
endmodule

bind usb2p_hub_regs usb2p_hub_regs_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_set(en_set), .fault_dis(fault_dis),
  .reset_done(reset_done), .warm_done(warm_done), .cfg_err(cfg_err),
  .pr_req(pr_req), .wpr_req(wpr_req), .port_word(port_word)
);

// File: tb/usb2p_hub_regs_bench.sv
module usb2p_hub_regs_bench;
  localparam int N = 10;
  localparam logic [31:0] DEF = 32'h0000_02A0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] ccs_in = '0, cas_in = '0, oc_in = '0;
  logic [4*N-1:0] speed_in = '0, link_val = '0, pls_out;
  logic [N-1:0] en_set = '0, fault_dis = '0, reset_done = '0, warm_done = '0;
  logic [N-1:0] link_we = '0, cfg_err = '0;
  logic [N-1:0] pr_req, wpr_req, pp_out;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  usb2p_hub_regs u_usb2p_hub_regs (.*);

  function automatic logic [11:0] pa(input int p);  // p is 1-based
    return 12'h480 + 12'h10 * 12'(p - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic pulse(ref logic [N-1:0] v, input int p);
    @(negedge clk); v[p-1] = 1'b1;
    @(negedge clk); v[p-1] = 1'b0;
  endtask

  task automatic t_reset();
    for (int p = 1; p <= N; p++) rd_chk("R1", pa(p), DEF);
    check("R1 pp_out", 32'(pp_out), 32'(10'h3FF));
  endtask

  task automatic t_decode();
    wr(pa(3), 32'h0000_82A0);
    rd_chk("R2 port3", pa(3), 32'h0000_82A0);
    rd_chk("R2 port2 untouched", pa(2), DEF);
    wr(pa(3) + 12'h4, 32'h0);
    rd_chk("R2 unaligned write ignored", pa(3), 32'h0000_82A0);
    rd_chk("R2 unaligned read", pa(3) + 12'h4, 32'h0);
    wr(12'h520, 32'h0);
    rd_chk("R2 beyond last port", 12'h520, 32'h0);
    rd_chk("R2 last port", pa(10), DEF);
    wr(pa(3), 32'h0000_0200);
  endtask

  task automatic t_rw();
    speed_in[3:0] = 4'h3;
    wr(pa(1), 32'h7E00_C20D);
    rd_chk("R11 rw fields, reserved zero, speed", pa(1), 32'h4E00_CEA0);
    wr(pa(1), 32'h0);
    rd_chk("R11 power off", pa(1), 32'h0000_0CA0);
    check("R11 pp_out", 32'(pp_out[0]), 32'h0);
    wr(pa(1), 32'h200);
    speed_in[3:0] = 4'h0;
  endtask

  task automatic t_pls();
    wr(pa(2), 32'h0000_0260);
    rd_chk("R8 no strobe ignored", pa(2), DEF);
    wr(pa(2), 32'h0001_0260);
    rd_chk("R8 strobe loads, reads 0", pa(2), 32'h0000_0260);
    check("R8 pls_out", 32'(pls_out[7:4]), 32'h3);
  endtask

  task automatic t_connect();
    @(negedge clk); ccs_in[3] = 1'b1;
    rd_chk("R5 connect", pa(4), 32'h0002_02A1);
    wr(pa(4), 32'h0000_0200);
    rd_chk("R3 write 0 keeps", pa(4), 32'h0002_02A1);
    wr(pa(4), 32'h0002_0200);
    rd_chk("R3 w1c", pa(4), 32'h0000_02A1);
    @(negedge clk); cas_in[3] = 1'b1;
    rd_chk("R5 cold attach", pa(4), 32'h0102_02A1);
    wr(pa(4), 32'h0002_0200);
    rd_chk("R3 w1c csc", pa(4), 32'h0100_02A1);
  endtask

  task automatic t_enable();
    wr(pa(5), 32'h0000_0202);
    rd_chk("R6 sw cannot enable", pa(5), DEF);
    pulse(en_set, 5);
    rd_chk("R6 enable event", pa(5), 32'h0000_02A2);
    wr(pa(5), 32'h0000_0202);
    rd_chk("R7 sw disable no pec", pa(5), DEF);
    pulse(en_set, 5);
    pulse(fault_dis, 5);
    rd_chk("R7 fault sets pec", pa(5), 32'h0004_02A0);
    wr(pa(5), 32'h0004_0200);
    rd_chk("R3 clear pec", pa(5), DEF);
  endtask

  task automatic t_busreset();
    wr(pa(6), 32'h0000_0210);
    rd_chk("R9 request set", pa(6), 32'h0000_02B0);
    repeat (3) @(negedge clk);
    check("R9 request held", 32'(pr_req[5]), 32'h1);
    pulse(reset_done, 6);
    rd_chk("R9 done sets prc", pa(6), 32'h0020_02A0);
    check("R9 pr_req low", 32'(pr_req[5]), 32'h0);
  endtask

  task automatic t_warm();
    wr(pa(7), 32'h8000_0200);
    rd_chk("R10 request set", pa(7), 32'h8000_02A0);
    pulse(warm_done, 7);
    rd_chk("R10 done sets wrc", pa(7), 32'h0008_02A0);
  endtask

  task automatic t_race();
    pulse(cfg_err, 8);
    rd_chk("R13 cfg error flag", pa(8), 32'h0080_02A0);
    @(negedge clk); bus_addr = pa(8); bus_wdata = 32'h0080_0200; bus_wr = 1'b1; cfg_err[7] = 1'b1;
    @(negedge clk); bus_wr = 1'b0; cfg_err[7] = 1'b0;
    rd_chk("R4 set beats clear", pa(8), 32'h0080_02A0);
    wr(pa(8), 32'h0080_0200);
    rd_chk("R4 later clear", pa(8), DEF);
  endtask

  task automatic t_oc();
    @(negedge clk); oc_in[8] = 1'b1;
    rd_chk("R12 over-current", pa(9), 32'h0010_02A8);
  endtask

  task automatic t_link_hw();
    @(negedge clk); link_val[39:36] = 4'h0; link_we[9] = 1'b1;
    @(negedge clk); link_we[9] = 1'b0;
    rd_chk("R13 hw link update", pa(10), 32'h0040_0200);
    @(negedge clk); bus_addr = pa(10); bus_wdata = 32'h0041_02E0; bus_wr = 1'b1;
    link_val[39:36] = 4'h2; link_we[9] = 1'b1;
    @(negedge clk); bus_wr = 1'b0; link_we[9] = 1'b0;
    rd_chk("R13 hw beats sw link write", pa(10), 32'h0040_0240);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_decode(); t_rw(); t_pls(); t_connect(); t_enable();
    t_busreset(); t_warm(); t_race(); t_oc(); t_link_hw();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule